// File: doc/BRIEF.md
# Sub-Multiframe CRC-4 Generator and Checker

This block runs a serial CRC-4 over the bit stream of a 2048 kbit/s framed link. An upstream framer supplies one bit per enabled clock, a marker on the first bit of each 2048-bit sub-multiframe, and a strobe on each of the four positions that carry CRC bits. Those positions are treated as zero while the remainder is built. The register is cleared at every sub-multiframe boundary, so each sub-multiframe is checked on its own.

On the final bit of a sub-multiframe the four-bit remainder is latched and a one-cycle valid pulse is raised. The latched value is the one the transmitter inserts into the CRC positions of the following sub-multiframe. When the optional check path is built in, the bits received at the marked positions are gathered and compared with the remainder latched at the end of the previous sub-multiframe. A one-cycle error pulse reports any difference.

Top module: `crc4_smf_gen`

## Requirements
- R1: The remainder is the division of the sub-multiframe's bits, first bit as highest power and multiplied by x^4, by x^4 + x + 1. `crc_out[3]` holds C1 and `crc_out[0]` holds C4.
- R2: Every bit accepted while `crc_pos` is high enters the register as 0, whatever level `bit_in` has.
- R3: In the cycle after the 2048th bit of a sub-multiframe is accepted, `crc_valid` is high for exactly one cycle and `crc_out` shows the new remainder.
- R4: `crc_out` does not change between two `crc_valid` pulses.
- R5: Each sub-multiframe starts from a cleared register. An `smf_start` in the middle of a sub-multiframe drops the partial one and starts counting a new one with the current bit as bit 1.
- R6: In check mode, the k-th `crc_pos` bit of a sub-multiframe (k = 1..4) is compared with C(k) of the previously latched remainder. Any difference gives a one-cycle `crc_err` together with `crc_valid`.
- R7: The first sub-multiframe completed after reset never raises `crc_err`.
- R8: While `bit_en` is low, `bit_in`, `smf_start` and `crc_pos` have no effect on any state.
- R9: A synchronous `rst` drives `crc_out`, `crc_valid` and `crc_err` to 0 and clears the check history. After reset no sub-multiframe completes until an `smf_start` has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Qualifies the bit and markers in this cycle |
| bit_in | input | 1 | Serial line bit |
| smf_start | input | 1 | Marks bit 1 of a sub-multiframe |
| crc_pos | input | 1 | Marks a CRC-bit position |
| crc_out | output | 4 | Latched remainder, C1 in bit 3 |
| crc_valid | output | 1 | One-cycle pulse when `crc_out` is updated |
| crc_err | output | 1 | One-cycle pulse on a received CRC mismatch |

## Verification
A wrong shift-register state or tap becomes visible only at the end of a sub-multiframe. It then shows as a wrong `crc_out` in the single cycle after the 2048th accepted bit, so up to 2048 enabled bits can pass before the fault is seen. A wrong bit count moves or removes the `crc_valid` pulse, and this is checked against the exact expected cycle. A fault in the captured CRC bits or in the check history shows as a wrong `crc_err`, also on that end cycle. In the error case it appears one sub-multiframe later than the remainder it was built from.

// File: rtl/crc4_smf_pkg.sv
package crc4_smf_pkg;
   localparam int CRC_W = 4;
   localparam logic [CRC_W-1:0] CRC_TAPS = 4'b0011;

   function automatic logic [CRC_W-1:0] crc_advance(
      input logic [CRC_W-1:0] cur,
      input logic             din,
      input logic [CRC_W-1:0] taps);
      logic fb;
      fb = din ^ cur[CRC_W-1];
      return {cur[CRC_W-2:0], 1'b0} ^ (fb ? taps : '0);
   endfunction
endpackage

// File: rtl/smf_bit_counter.sv
module smf_bit_counter #(
   parameter int SMF_BITS = 2048
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic smf_start,
   output logic accept,
   output logic restart,
   output logic last
);
   localparam int CNT_W = $clog2(SMF_BITS);

   if (SMF_BITS < 8) begin : g_bad_len
      $error("SMF_BITS must be at least 8");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             synced_q;
   logic [CNT_W-1:0] cur_idx;

   assign accept  = bit_en && (smf_start || synced_q);
   assign restart = bit_en && smf_start;
   assign cur_idx = restart ? '0 : cnt_q;
   assign last    = accept && (cur_idx == CNT_W'(SMF_BITS - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q    <= '0;
         synced_q <= 1'b0;
      end else if (accept) begin
         cnt_q    <= last ? '0 : cur_idx + 1'b1;
         synced_q <= 1'b1;
      end
   end

   assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_W'(SMF_BITS - 1));

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !bit_en |=> $stable(cnt_q) && $stable(synced_q));
endmodule

// File: rtl/crc4_shift_reg.sv
module crc4_shift_reg
   import crc4_smf_pkg::*;
#(
   parameter logic [CRC_W-1:0] TAPS = CRC_TAPS
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             accept,
   input  logic             restart,
   input  logic             last,
   input  logic             din,
   output logic [CRC_W-1:0] rem_next
);
   logic [CRC_W-1:0] rem_q;
   logic [CRC_W-1:0] base;

   assign base     = restart ? '0 : rem_q;
   assign rem_next = crc_advance(base, din, TAPS);

   always_ff @(posedge clk) begin
      if (rst)         rem_q <= '0;
      else if (accept) rem_q <= last ? '0 : rem_next;
   end

   assert_cleared_after_end_R5: assert property (@(posedge clk) disable iff (rst)
      last |=> rem_q == '0);

   assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
      !accept |=> $stable(rem_q));
endmodule

// File: rtl/crc4_rx_check.sv
module crc4_rx_check
   import crc4_smf_pkg::*;
#(
   parameter bit CHECK_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             accept,
   input  logic             restart,
   input  logic             last,
   input  logic             crc_pos,
   input  logic             din,
   input  logic [CRC_W-1:0] ref_crc,
   output logic             err
);
   localparam int IDX_W = $clog2(CRC_W + 1);

   if (CHECK_EN) begin : g_check
      logic [IDX_W-1:0] idx_q, idx_cur;
      logic [CRC_W-1:0] rx_q, rx_cur, rx_full;
      logic             have_prev_q;
      logic             err_q;

      assign idx_cur = restart ? '0 : idx_q;
      assign rx_cur  = restart ? '0 : rx_q;

      always_comb begin
         rx_full = rx_cur;
         if (crc_pos && idx_cur < IDX_W'(CRC_W))
            rx_full[CRC_W-1-int'(idx_cur)] = din;
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            idx_q       <= '0;
            rx_q        <= '0;
            have_prev_q <= 1'b0;
            err_q       <= 1'b0;
         end else begin
            err_q <= 1'b0;
            if (accept) begin
               if (last) begin
                  err_q       <= have_prev_q && (rx_full != ref_crc);
                  have_prev_q <= 1'b1;
                  idx_q       <= '0;
                  rx_q        <= '0;
               end else begin
                  rx_q <= rx_full;
                  if (crc_pos && idx_cur < IDX_W'(CRC_W)) idx_q <= idx_cur + 1'b1;
                  else                                    idx_q <= idx_cur;
               end
            end
         end
      end

      assign err = err_q;

      assert_first_quiet_R7: assert property (@(posedge clk) disable iff (rst)
         err_q |-> $past(have_prev_q));

      assert_err_pulse_R6: assert property (@(posedge clk) disable iff (rst)
         err_q |=> !err_q);
   end else begin : g_nocheck
      assign err = 1'b0;
   end
endmodule

// File: rtl/crc4_smf_gen.sv
module crc4_smf_gen
   import crc4_smf_pkg::*;
#(
   parameter int               SMF_BITS = 2048,
   parameter bit               CHECK_EN = 1'b1,
   parameter logic [CRC_W-1:0] TAPS     = CRC_TAPS
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bit_en,
   input  logic             bit_in,
   input  logic             smf_start,
   input  logic             crc_pos,
   output logic [CRC_W-1:0] crc_out,
   output logic             crc_valid,
   output logic             crc_err
);
   logic             accept, restart, last;
   logic             masked_bit;
   logic [CRC_W-1:0] rem_next;

   assign masked_bit = bit_in & ~crc_pos;

   smf_bit_counter #(.SMF_BITS(SMF_BITS)) u_cnt (
      .clk(clk), .rst(rst), .bit_en(bit_en), .smf_start(smf_start),
      .accept(accept), .restart(restart), .last(last));

   crc4_shift_reg #(.TAPS(TAPS)) u_reg (
      .clk(clk), .rst(rst), .accept(accept), .restart(restart),
      .last(last), .din(masked_bit), .rem_next(rem_next));

   crc4_rx_check #(.CHECK_EN(CHECK_EN)) u_chk (
      .clk(clk), .rst(rst), .accept(accept), .restart(restart),
      .last(last), .crc_pos(crc_pos), .din(bit_in), .ref_crc(crc_out),
      .err(crc_err));

   always_ff @(posedge clk) begin
      if (rst) begin
         crc_out   <= '0;
         crc_valid <= 1'b0;
      end else begin
         crc_valid <= last;
         if (last) crc_out <= rem_next;
      end
   end

   assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
      crc_valid |=> !crc_valid);

   assert_out_stable_R4: assert property (@(posedge clk) disable iff (rst)
      !crc_valid && !$past(rst) |-> $stable(crc_out));

   assert_err_with_valid_R6: assert property (@(posedge clk) disable iff (rst)
      crc_err |-> crc_valid);

   assert_no_end_idle_R8: assert property (@(posedge clk) disable iff (rst)
      !$past(bit_en) |-> !crc_valid);
endmodule

// File: tb/crc4_smf_gen_test.sv
`timescale 1ns/1ps
module crc4_smf_gen_test;
   localparam int N = 2048;
   localparam int NV = 6;
   // {seed[15:0], corrupt[3:0], 3'b0, gap}
   localparam logic [23:0] VEC [NV] = '{
      {16'h0000, 4'hF, 4'h0},
      {16'hACE1, 4'h0, 4'h0},
      {16'h1234, 4'h8, 4'h1},
      {16'hBEEF, 4'h0, 4'h1},
      {16'h0F0F, 4'h1, 4'h0},
      {16'hFFFF, 4'h0, 4'h0}};

   logic clk = 1'b0, rst = 1'b1;
   logic bit_en = 0, bit_in = 0, smf_start = 0, crc_pos = 0;
   logic [3:0] crc_out;
   logic crc_valid, crc_err;
   int checks = 0, fails = 0;
   logic [3:0] prev_crc = 4'h0;
   bit have_prev = 0;
   logic dat [N];

   always #10 clk = ~clk;

   crc4_smf_gen uut (.clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
      .smf_start(smf_start), .crc_pos(crc_pos), .crc_out(crc_out),
      .crc_valid(crc_valid), .crc_err(crc_err));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic bit is_pos(input int i);
      return (i % 512) == 0;
   endfunction

   // long division of the message times x^4 by 10011
   function automatic logic [3:0] ref_crc();
      logic [4:0] r = '0;
      for (int i = 0; i < N + 4; i++) begin
         logic b;
         b = (i < N) ? (is_pos(i) ? 1'b0 : dat[i]) : 1'b0;
         r = {r[3:0], b};
         if (r[4]) r = r ^ 5'b10011;
      end
      return r[3:0];
   endfunction

   task automatic fill(input logic [15:0] seed, input logic [3:0] corrupt);
      logic [15:0] s = seed;
      for (int i = 0; i < N; i++) begin
         s = s ^ (s << 7); s = s ^ (s >> 9); s = s ^ (s << 8);
         dat[i] = s[0];
      end
      for (int k = 0; k < 4; k++) dat[k*512] = prev_crc[3-k] ^ corrupt[3-k];
   endtask

   task automatic idle_noise();
      @(negedge clk);
      bit_en = 0; bit_in = 1; smf_start = 1; crc_pos = 1;
   endtask

   task automatic send_smf(input logic [15:0] seed, input logic [3:0] corrupt,
                           input bit gap, input string tag);
      logic [3:0] exp;
      bit exp_err;
      fill(seed, corrupt);
      exp = ref_crc();
      exp_err = have_prev && (corrupt != 0);
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         if (i == N - 1) begin
            chk(crc_out == prev_crc, {tag, " R4 hold"}, crc_out, prev_crc);
            chk(!crc_valid, {tag, " R3 no early valid"}, crc_valid, 0);
         end
         bit_en = 1; bit_in = dat[i]; smf_start = (i == 0); crc_pos = is_pos(i);
         if (gap && i != N - 1) idle_noise();
      end
      @(negedge clk);
      bit_en = 0; smf_start = 0; crc_pos = 0; bit_in = 0;
      chk(crc_valid, {tag, " R3 valid"}, crc_valid, 1);
      chk(crc_out == exp, {tag, " R1 R2 R5 remainder"}, crc_out, exp);
      chk(crc_err == exp_err, {tag, " R6 R7 error flag"}, crc_err, exp_err);
      @(negedge clk);
      chk(!crc_valid && !crc_err, {tag, " R3 one-cycle pulse"}, {crc_valid, crc_err}, 0);
      prev_crc = exp;
      have_prev = 1;
   endtask

   task automatic send_part(input int n, input logic [15:0] seed);
      logic [15:0] s = seed;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         s = s ^ (s << 7); s = s ^ (s >> 9); s = s ^ (s << 8);
         bit_en = 1; bit_in = s[0]; smf_start = (i == 0); crc_pos = s[3];
      end
      @(negedge clk);
      bit_en = 0; smf_start = 0; crc_pos = 0;
   endtask

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      int seen;
      repeat (4) @(negedge clk);
      rst = 0;
      @(negedge clk);
      chk(crc_out == 0 && !crc_valid && !crc_err, "R9 reset state",
          {crc_out, crc_valid, crc_err}, 0);

      for (int v = 0; v < NV; v++)
         send_smf(VEC[v][23:8], VEC[v][7:4], VEC[v][0], $sformatf("vec%0d", v));

      // R5: mid-SMF restart discards the partial block
      send_part(700, 16'h5A5A);
      send_smf(16'h7777, 4'h0, 1'b0, "resync R5");

      // R9: reset mid-SMF, then no completion without smf_start
      send_part(300, 16'h3C3C);
      @(negedge clk); rst = 1;
      @(negedge clk); rst = 0;
      @(negedge clk);
      chk(crc_out == 0 && !crc_valid && !crc_err, "R9 reset mid-block",
          {crc_out, crc_valid, crc_err}, 0);
      prev_crc = 0; have_prev = 0;
      seen = 0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (crc_valid) seen++;
         bit_en = 1; bit_in = i[2]; smf_start = 0; crc_pos = i[5];
      end
      @(negedge clk);
      if (crc_valid) seen++;
      bit_en = 0; crc_pos = 0;
      @(negedge clk);
      if (crc_valid) seen++;
      chk(seen == 0, "R9 unsynced no valid", seen, 0);

      // R7: first block after reset with bad CRC bits is not flagged
      send_smf(16'h9999, 4'hF, 1'b0, "post-reset R7");
      send_smf(16'h2468, 4'h4, 1'b1, "post-reset R6");

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule